// File: doc/BRIEF.md
# Toggle-Weighted Power Estimator

This block is a hardware power estimator attached beside one monitored circuit component. It watches a bus made of that component's input and output bits, and each time a power strobe arrives it reports how much power the component used over the strobe period that just ended. The estimate is linear. Every watched bit has its own 32-bit weight. A bit adds its weight to the total only if its value changed between the sample taken at the previous strobe and the sample taken at this strobe.

The design has no multiplier. Each per-bit toggle is a single XOR bit, and that bit gates its weight through an AND across the whole word. A widening adder tree sums the gated weights. The result is clamped to the all-ones 32-bit value instead of wrapping, and is then registered. A one-cycle valid pulse goes out with each new figure. The estimator sits next to the monitored logic. It is fed the same clock and a periodic strobe from a strobe generator. Combining the figures of many components is left to logic outside this block.

Top module: `toggle_power_est`

## Requirements
- R1: While reset is asserted and after reset is released, and until the first strobe, `power_o` is 0 and `power_vld_o` is 0.
- R2: `power_vld_o` is high for exactly the one cycle that follows each cycle in which `strobe_i` is high, and is low otherwise.
- R3: The first strobe after any reset reports a power of 0. That strobe only captures the first sample.
- R4: On each later strobe, `power_o` equals the sum of the weights of all bits of `mon_i` whose value differs between this strobe's sample and the previous strobe's sample. The weight of bit i is `coef_i[i*32 +: 32]`, sampled in the strobe cycle.
- R5: Bits that did not toggle add nothing. A strobe whose sample equals the previous sample reports 0 whatever the weights are.
- R6: If the true sum is larger than 0xFFFFFFFF, `power_o` is 0xFFFFFFFF. If the true sum is at most 0xFFFFFFFF, `power_o` is the exact sum.
- R7: `power_o` holds its value in every cycle that does not follow a strobe.
- R8: `mon_i` is sampled only in strobe cycles. Changes between strobes that return to the sampled value add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the monitored component |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Power strobe; one cycle high per evaluation period |
| mon_i | input | MON_W (16) | Watched input/output bits of the component |
| coef_i | input | MON_W*32 (512) | Per-bit weights, bit i at [i*32 +: 32] |
| power_o | output | 32 | Power of the last completed strobe period |
| power_vld_o | output | 1 | One-cycle pulse with each new power value |

## Verification
The assertions take `strobe_i` and `mon_i` as clean synchronous levels. They keep their own copy of the previous strobe sample and track their own first-strobe state after reset. They expect `coef_i` to be steady across the strobe cycle. The stimulus changes inputs only on the falling clock edge and holds the weights constant around each strobe. It leaves gaps of idle cycles between strobes, so the one-cycle valid pulse and the hold between strobes can both be observed. It also wiggles `mon_i` during the gaps and returns it to the sampled value, which checks that changes between strobes are ignored.

// File: rtl/toggle_pwr_pkg.sv
// Package: shared widths and helper functions for the toggle power estimator.
// Assumes: coefficient width never exceeds the power word width.
package toggle_pwr_pkg;

    localparam int unsigned PWR_W  = 32;
    localparam int unsigned COEF_W = 32;

    typedef logic [PWR_W-1:0] power_t;

    // Number of leaves of the adder tree: next power of two at or above n.
    function automatic int unsigned leaf_count(input int unsigned n);
        int unsigned c;
        c = 1;
        while (c < n) c = c * 2;
        return c;
    endfunction

endpackage

// File: rtl/toggle_history.sv
// Module: toggle_history
// Holds the sample taken at the last strobe and flags which watched bits
// differ between that sample and the live bus. The flags go to zero until a
// first sample exists, so the first strobe after reset sees no toggles.
// Assumes: strobe_i is a single-cycle pulse synchronous to clk.
module toggle_history #(
    parameter int unsigned MON_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [MON_W-1:0] mon_i,
    output logic [MON_W-1:0] toggle_o
);

    logic [MON_W-1:0] held_q;
    logic             primed_q;

    // Capture the live sample on each strobe; mark history as primed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q   <= '0;
            primed_q <= 1'b0;
        end else if (strobe_i) begin
            held_q   <= mon_i;
            primed_q <= 1'b1;
        end
    end

    // Per-bit toggle detection between the held and the live sample.
    always_comb begin
        toggle_o = primed_q ? (held_q ^ mon_i) : '0;
    end

endmodule

// File: rtl/coef_gate.sv
// Module: coef_gate
// Replaces each weight-times-toggle product with an AND of the toggle bit
// across the whole weight word. Output is the flattened gated weights.
// Assumes: weights are packed with bit i at [i*COEF_W +: COEF_W].
module coef_gate #(
    parameter int unsigned MON_W  = 16,
    parameter int unsigned COEF_W = 32
) (
    input  logic [MON_W-1:0]        toggle_i,
    input  logic [MON_W*COEF_W-1:0] coef_i,
    output logic [MON_W*COEF_W-1:0] gated_o
);

    for (genvar g = 0; g < MON_W; g++) begin : g_bit
        // Gate one weight by its toggle flag.
        assign gated_o[g*COEF_W +: COEF_W] =
            coef_i[g*COEF_W +: COEF_W] & {COEF_W{toggle_i[g]}};
    end

endmodule

// File: rtl/sat_adder_tree.sv
// Module: sat_adder_tree
// Binary adder tree in heap layout, widened so that no partial sum can
// overflow, with a final clamp to the all-ones output word.
// Assumes: COEF_W <= OUT_W; padding leaves are zero.
module sat_adder_tree
    import toggle_pwr_pkg::*;
#(
    parameter int unsigned MON_W  = 16,
    parameter int unsigned COEF_W = 32,
    parameter int unsigned OUT_W  = 32
) (
    input  logic [MON_W*COEF_W-1:0] term_i,
    output logic [OUT_W-1:0]        sum_o
);

    localparam int unsigned LEAVES = leaf_count(MON_W);
    localparam int unsigned LVL    = $clog2(LEAVES);
    localparam int unsigned SUM_W  = OUT_W + LVL + 1;

    logic [SUM_W-1:0] node [1:2*LEAVES-1];

    for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
        if (g < MON_W) begin : g_real
            // Zero-extend one gated weight into a leaf.
            assign node[LEAVES+g] = {{(SUM_W-COEF_W){1'b0}}, term_i[g*COEF_W +: COEF_W]};
        end else begin : g_pad
            // Padding leaf contributes nothing.
            assign node[LEAVES+g] = '0;
        end
    end

    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        // Internal node adds its two children.
        assign node[n] = node[2*n] + node[2*n+1];
    end

    // Clamp the full-width total to the output range.
    always_comb begin
        if (|node[1][SUM_W-1:OUT_W]) sum_o = '1;
        else                         sum_o = node[1][OUT_W-1:0];
    end

endmodule

// File: rtl/toggle_power_est.sv
// Module: toggle_power_est (top)
// Toggle-weighted power estimator for one monitored component. On each
// strobe, the weights of bits that changed since the previous strobe are
// summed (saturating) and registered; a valid pulse follows one cycle later.
// Assumes: single clock domain, strobe one cycle wide, weights steady in
// the strobe cycle.
module toggle_power_est
    import toggle_pwr_pkg::*;
#(
    parameter int unsigned MON_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe_i,
    input  logic [MON_W-1:0]        mon_i,
    input  logic [MON_W*COEF_W-1:0] coef_i,
    output logic [PWR_W-1:0]        power_o,
    output logic                    power_vld_o
);

    logic [MON_W-1:0]        toggle;
    logic [MON_W*COEF_W-1:0] gated;
    power_t                  sum;
    power_t                  power_q;
    logic                    vld_q;

    toggle_history #(.MON_W(MON_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .mon_i    (mon_i),
        .toggle_o (toggle)
    );

    coef_gate #(.MON_W(MON_W), .COEF_W(COEF_W)) u_gate (
        .toggle_i (toggle),
        .coef_i   (coef_i),
        .gated_o  (gated)
    );

    sat_adder_tree #(.MON_W(MON_W), .COEF_W(COEF_W), .OUT_W(PWR_W)) u_tree (
        .term_i (gated),
        .sum_o  (sum)
    );

    // Latch the period's power on the strobe and raise valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            power_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= strobe_i;
            if (strobe_i) power_q <= sum;
        end
    end

    assign power_o     = power_q;
    assign power_vld_o = vld_q;

endmodule

// File: rtl/toggle_power_est_chk.sv
// Module: toggle_power_est_chk
// Checker bound to toggle_power_est. Keeps its own copy of the last strobe
// sample and its own first-strobe flag, so it is independent of the design.
module toggle_power_est_chk #(
    parameter int unsigned MON_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_i,
    input logic [MON_W-1:0] mon_i,
    input logic [31:0]      power_o,
    input logic             power_vld_o
);

    logic [MON_W-1:0] last_q;
    logic             seen_q;

    // Shadow of the previous strobe sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            seen_q <= 1'b0;
        end else if (strobe_i) begin
            last_q <= mon_i;
            seen_q <= 1'b1;
        end
    end

    assert_vld_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> power_vld_o);

    assert_vld_only_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> !power_vld_o);

    assert_first_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !seen_q) |=> (power_o == 32'd0));

    assert_no_toggle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && (mon_i == last_q)) |=> (power_o == 32'd0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(power_o));

endmodule

bind toggle_power_est toggle_power_est_chk #(.MON_W(MON_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_i    (strobe_i),
    .mon_i       (mon_i),
    .power_o     (power_o),
    .power_vld_o (power_vld_o)
);

// File: tb/toggle_power_est_tb_top.sv
// Bench for toggle_power_est: directed corners plus seeded random strobes,
// compared against a reference weighted toggle sum computed here.
module toggle_power_est_tb_top;

    localparam int MON_W = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                strobe_i = 1'b0;
    logic [MON_W-1:0]    mon_i = '0;
    logic [MON_W*32-1:0] coef_i = '0;
    logic [31:0]         power_o;
    logic                power_vld_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [MON_W-1:0] ref_last = '0;
    bit               ref_seen = 1'b0;

    always #4 clk = ~clk;

    toggle_power_est #(.MON_W(MON_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe_i),
        .mon_i       (mon_i),
        .coef_i      (coef_i),
        .power_o     (power_o),
        .power_vld_o (power_vld_o)
    );

    function automatic logic [31:0] ref_power(input logic [MON_W-1:0] a,
                                              input logic [MON_W-1:0] b,
                                              input logic [MON_W*32-1:0] w);
        logic [63:0] acc;
        acc = 64'd0;
        for (int i = 0; i < MON_W; i++)
            if (a[i] != b[i]) acc += {32'd0, w[i*32 +: 32]};
        return (acc > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : acc[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; strobe_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", {31'd0, power_vld_o}, 32'd0);
        check("R1", power_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", power_o, 32'd0);
        ref_seen = 1'b0;
    endtask

    // One strobe with the given sample; checks value, pulse and hold.
    task automatic strobe(input string req, input logic [MON_W-1:0] s);
        logic [31:0] exp;
        exp = ref_seen ? ref_power(ref_last, s, coef_i) : 32'd0;
        mon_i = s; strobe_i = 1'b1;
        @(negedge clk);
        strobe_i = 1'b0;
        check("R2", {31'd0, power_vld_o}, 32'd1);
        check(req, power_o, exp);
        ref_last = s; ref_seen = 1'b1;
        @(negedge clk);
        check("R2", {31'd0, power_vld_o}, 32'd0);
        check("R7", power_o, exp);
    endtask

    task automatic set_coefs(input logic [31:0] mask);
        for (int i = 0; i < MON_W; i++) coef_i[i*32 +: 32] = $urandom & mask;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        set_coefs(32'h00FF_FFFF);
        strobe("R3", 16'hA5C3);
        strobe("R5", 16'hA5C3);
        coef_i[0 +: 32] = 32'd17;
        coef_i[15*32 +: 32] = 32'd1000;
        strobe("R4", 16'hA5C2);
        strobe("R4", 16'h25C2);
        // R8: wiggle between strobes, return to sampled value.
        for (int k = 0; k < 4; k++) begin
            mon_i = 16'($urandom);
            @(negedge clk);
        end
        strobe("R8", 16'h25C2);
        for (int k = 0; k < 60; k++) begin
            set_coefs(k < 30 ? 32'h0FFF_FFFF : 32'h3FFF_FFFF);
            strobe("R4", 16'($urandom));
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        // R6: exact fit, then overflow, then heavy overflow.
        coef_i = '0;
        coef_i[0 +: 32] = 32'h8000_0000;
        coef_i[32 +: 32] = 32'h7FFF_FFFF;
        strobe("R6", 16'h0000);
        strobe("R6", 16'h0003);
        coef_i[32 +: 32] = 32'h8000_0000;
        strobe("R6", 16'h0000);
        set_coefs(32'hFFFF_FFFF);
        for (int i = 0; i < MON_W; i++) coef_i[i*32 + 31] = 1'b1;
        strobe("R6", 16'hFFFF);
        // Reset mid-run: first strobe again reports zero.
        do_reset();
        strobe("R3", 16'h1234);
        strobe("R4", 16'hEDCB);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule